// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block is a 32 KB data cache that sits between a 32-bit load/store port and a memory port one line wide. It holds 4 ways of 256 sets, and each line is 32 bytes (eight 32-bit words). Loads and stores of byte, halfword or word size are served from the cache. A store that hits changes only the cached copy and records which bytes were modified. Memory is only updated when a modified line is evicted.

Dirty state is tracked per byte. When a line leaves the cache, only its modified bytes are sent to memory, under a 32-bit byte-enable mask. A line that holds no modified bytes is dropped without any memory write. On a miss, the cache first writes back the victim if needed, then fetches the whole line. After that it completes the load, or merges the store data into the fetched line.

The victim is an invalid way if the set has one. Otherwise a 2-bit round-robin pointer kept for each set picks it. While a writeback or fill is in progress, the load/store port stalls.

Top module: `wbc_top`

## Requirements
- R1: Address bits [12:5] select one of 256 sets, bits [4:2] select the word within the 32-byte line, and bits [31:13] are the tag. Lines that differ only in tag compete for the 4 ways of one set, and lines in other sets are not disturbed.
- R2: A request is taken when `cpu_req_valid` and `cpu_req_ready` are both high. Each request produces exactly one single-cycle `cpu_rsp_valid` pulse. On a hit, the pulse comes one clock after the accepting edge.
- R3: A read returns the whole naturally aligned 32-bit word that contains the address. Byte lane k of `cpu_rsp_rdata` (bits 8k+7:8k) holds the byte at word offset k.
- R4: `cpu_req_size` encodes 0 = byte, 1 = halfword, 2 = word, and accesses are naturally aligned. Write data is lane-aligned: the byte at word offset k is taken from bits 8k+7:8k of `cpu_req_wdata`. Only the addressed bytes change.
- R5: A write hit updates only the cache and marks the written bytes dirty. It raises no memory request.
- R6: A read miss raises one memory read (`mem_req_write`=0, `mem_req_be`=0) at the line-aligned address. It installs the whole returned line, then returns the requested word.
- R7: A write miss allocates and fills the line in the same way. It then merges the write data into the line, and only the written bytes become dirty.
- R8: When the chosen victim holds dirty bytes, a memory write (`mem_req_write`=1) goes out before the fill read. It carries the victim's line address, the line data, and `mem_req_be` bit b set exactly for each dirty byte b.
- R9: A victim with no dirty bytes causes no memory write.
- R10: The victim is the lowest-numbered invalid way of the set, if there is one. Otherwise it is the way named by the set's 2-bit pointer. The pointer is 0 after reset and advances by one, wrapping, on every allocation in that set.
- R11: `cpu_req_ready` is low while a memory request is being raised, and through the whole miss.
- R12: After reset all lines are invalid, `cpu_req_ready` is high, and `mem_req_valid` and `cpu_rsp_valid` are low.
- R13: Once `mem_req_valid` is high, it stays high with a stable address and direction until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Load/store request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_req_wdata | input | 32 | Lane-aligned store data |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_rdata | output | 32 | Aligned word read |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = writeback, 0 = line fill |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 256 | Writeback line data |
| mem_req_be | output | 32 | Per-byte write enables of the writeback |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_rdata | input | 256 | Fill line data |

## Verification
Two functions can fall in the same cycle here.

The first pair is the fill return and the write-miss merge. The fill and the store's bytes and dirty marks all go into the way in one array write. The bench provokes this with a word store to a line that is not resident. It judges the result by reading back the stored word and a neighbouring word that must still hold the memory pattern.

The second pair is victim selection and the pointer step. Both happen on the lookup cycle of a miss. The bench fills one set with four lines while a dirty line is resident, then adds further lines to the same set. It checks that no writeback occurs while invalid ways remain. It then checks that the evicted line addresses and byte masks follow the pointer order.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FREQ,
    ST_FWAIT
  } cache_state_e;

  // Byte lanes touched within one 32-bit word for a naturally aligned access.
  function automatic logic [3:0] lane_mask(logic [1:0] size, logic [1:0] off);
    case (size)
      SZ_BYTE: lane_mask = 4'b0001 << off;
      SZ_HALF: lane_mask = 4'b0011 << {off[1], 1'b0};
      default: lane_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/wbc_way.sv
module wbc_way #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned TAG_W      = 19,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [LINE_BYTES*8-1:0]   wr_line,
  input  logic [LINE_BYTES-1:0]     wr_dirty,
  output logic                      rd_valid,
  output logic [TAG_W-1:0]          rd_tag,
  output logic [LINE_BYTES*8-1:0]   rd_line,
  output logic [LINE_BYTES-1:0]     rd_dirty
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [TAG_W-1:0]        tag_mem   [SETS];
  logic [LINE_BYTES*8-1:0] data_mem  [SETS];
  logic [LINE_BYTES-1:0]   dirty_mem [SETS];
  logic [SETS-1:0]         valid_q;

  // Inferred RAMs: registered read, read output holds until the next rd_en.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]   <= wr_tag;
      data_mem[wr_idx]  <= wr_line;
      dirty_mem[wr_idx] <= wr_dirty;
    end
    if (rd_en) begin
      rd_tag   <= tag_mem[rd_idx];
      rd_line  <= data_mem[rd_idx];
      rd_dirty <= dirty_mem[rd_idx];
    end
  end

  // Valid bits need reset, so they live in flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_idx];
    end
  end

endmodule

// File: rtl/wbc_victim.sv
module wbc_victim #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned WAYS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_W-1:0]         idx,
  input  logic [WAYS-1:0]          way_valid,
  input  logic                     advance,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic             found;

  // Lowest invalid way wins; otherwise the set's round-robin pointer.
  always_comb begin
    victim = ptr_q[idx];
    found  = 1'b0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (!way_valid[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SETS); s++) ptr_q[s] <= '0;
    end else if (advance) begin
      ptr_q[idx] <= ptr_q[idx] + 1'b1;
    end
  end

  // R10
  prefer_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (way_valid != '1) |-> !way_valid[victim]);

endmodule

// File: rtl/wbc_top.sv
module wbc_top import wbc_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned SETS       = 256,
  parameter int unsigned WAYS       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req_valid,
  output logic                     cpu_req_ready,
  input  logic                     cpu_req_write,
  input  logic [ADDR_W-1:0]        cpu_req_addr,
  input  logic [1:0]               cpu_req_size,
  input  logic [31:0]              cpu_req_wdata,
  output logic                     cpu_rsp_valid,
  output logic [31:0]              cpu_rsp_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_write,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [LINE_BYTES*8-1:0]  mem_req_wdata,
  output logic [LINE_BYTES-1:0]    mem_req_be,
  input  logic                     mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]  mem_rsp_rdata
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned LINE_W = LINE_BYTES * 8;

  // Bytes of the line touched by an access.
  function automatic logic [LINE_BYTES-1:0] line_mask(logic [OFF_W-1:0] off, logic [1:0] size);
    line_mask = '0;
    line_mask[{off[OFF_W-1:2], 2'b00} +: 4] = lane_mask(size, off[1:0]);
  endfunction

  // Lane-aligned store data merged into a line under a byte mask.
  function automatic logic [LINE_W-1:0] merge_line(logic [LINE_W-1:0] ln, logic [31:0] wd,
                                                    logic [LINE_BYTES-1:0] m);
    merge_line = ln;
    for (int b = 0; b < int'(LINE_BYTES); b++)
      if (m[b]) merge_line[b*8 +: 8] = wd[(b % 4)*8 +: 8];
  endfunction

  function automatic logic [31:0] word_of(logic [LINE_W-1:0] ln, logic [OFF_W-1:0] off);
    word_of = ln[off[OFF_W-1:2]*32 +: 32];
  endfunction

  cache_state_e state_q, state_d;
  logic              req_write_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [1:0]        req_size_q;
  logic [31:0]       req_wdata_q;
  logic [WAY_W-1:0]  vic_q;
  logic              rsp_valid_q;
  logic [31:0]       rsp_data_q;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  assign req_idx = req_addr_q[OFF_W +: IDX_W];
  assign req_tag = req_addr_q[ADDR_W-1 -: TAG_W];
  assign req_off = req_addr_q[OFF_W-1:0];

  logic [WAYS-1:0]       way_valid, hit_vec, way_wr;
  logic [TAG_W-1:0]      way_tag   [WAYS];
  logic [LINE_W-1:0]     way_line  [WAYS];
  logic [LINE_BYTES-1:0] way_dirty [WAYS];
  logic [WAY_W-1:0]      hit_way, vic_way;
  logic [LINE_W-1:0]     base_line, new_line;
  logic [LINE_BYTES-1:0] base_dirty, new_dirty, acc_mask;

  // Named internal events.
  logic accept_evt, hit_evt, miss_evt, mem_fire, wb_done_evt, fill_evt, vic_dirty;
  assign accept_evt  = cpu_req_valid && cpu_req_ready;
  assign hit_evt     = (state_q == ST_LOOKUP) && (|hit_vec);
  assign miss_evt    = (state_q == ST_LOOKUP) && !(|hit_vec);
  assign mem_fire    = mem_req_valid && mem_req_ready;
  assign wb_done_evt = (state_q == ST_WBACK) && mem_fire;
  assign fill_evt    = (state_q == ST_FWAIT) && mem_rsp_valid;
  assign vic_dirty   = way_valid[vic_way] && (|way_dirty[vic_way]);

  generate
    for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
      wbc_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)) u_way (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (accept_evt),
        .rd_idx   (cpu_req_addr[OFF_W +: IDX_W]),
        .wr_en    (way_wr[w]),
        .wr_idx   (req_idx),
        .wr_tag   (req_tag),
        .wr_line  (new_line),
        .wr_dirty (new_dirty),
        .rd_valid (way_valid[w]),
        .rd_tag   (way_tag[w]),
        .rd_line  (way_line[w]),
        .rd_dirty (way_dirty[w])
      );
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
      assign way_wr[w]  = (hit_evt && req_write_q && (hit_way == WAY_W'(w))) ||
                          (fill_evt && (vic_q == WAY_W'(w)));
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < int'(WAYS); w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  wbc_victim #(.IDX_W(IDX_W), .WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (req_idx),
    .way_valid (way_valid),
    .advance   (miss_evt),
    .victim    (vic_way)
  );

  // One write path for both hit updates and fill (with merge on a write miss).
  assign acc_mask   = line_mask(req_off, req_size_q);
  assign base_line  = (state_q == ST_LOOKUP) ? way_line[hit_way] : mem_rsp_rdata;
  assign base_dirty = (state_q == ST_LOOKUP) ? way_dirty[hit_way] : '0;
  assign new_line   = req_write_q ? merge_line(base_line, req_wdata_q, acc_mask) : base_line;
  assign new_dirty  = base_dirty | (req_write_q ? acc_mask : '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept_evt) state_d = ST_LOOKUP;
      ST_LOOKUP: if (hit_evt) state_d = ST_IDLE;
                 else state_d = vic_dirty ? ST_WBACK : ST_FREQ;
      ST_WBACK:  if (mem_fire) state_d = ST_FREQ;
      ST_FREQ:   if (mem_fire) state_d = ST_FWAIT;
      ST_FWAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_write_q <= 1'b0;
      req_addr_q  <= '0;
      req_size_q  <= '0;
      req_wdata_q <= '0;
      vic_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= hit_evt || fill_evt;
      if (accept_evt) begin
        req_write_q <= cpu_req_write;
        req_addr_q  <= cpu_req_addr;
        req_size_q  <= cpu_req_size;
        req_wdata_q <= cpu_req_wdata;
      end
      if (miss_evt) vic_q <= vic_way;
      if (hit_evt || fill_evt) rsp_data_q <= word_of(new_line, req_off);
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;
  assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FREQ);
  assign mem_req_write = (state_q == ST_WBACK);
  assign mem_req_addr  = (state_q == ST_WBACK) ? {way_tag[vic_q], req_idx, {OFF_W{1'b0}}}
                                               : {req_tag, req_idx, {OFF_W{1'b0}}};
  assign mem_req_wdata = way_line[vic_q];
  assign mem_req_be    = (state_q == ST_WBACK) ? way_dirty[vic_q] : '0;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R11
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  // R8
  wb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> ((mem_req_be != '0) && (mem_req_addr[OFF_W-1:0] == '0)));

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done_evt |=> (mem_req_valid && !mem_req_write));

  // R6
  fill_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> ((mem_req_be == '0) && (mem_req_addr[OFF_W-1:0] == '0)));

  // R5
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (!mem_req_valid && cpu_rsp_valid));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

endmodule

// File: tb/test_wbc_top.sv
`timescale 1ns/1ps
module test_wbc_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [31:0]  cpu_req_addr, cpu_req_wdata, cpu_rsp_rdata;
  logic [1:0]   cpu_req_size;
  logic         cpu_rsp_valid;
  logic         mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [31:0]  mem_req_addr, mem_req_be;
  logic [255:0] mem_req_wdata, mem_rsp_rdata;

  always #4 clk = ~clk;

  wbc_top i_wbc_top (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_size(cpu_req_size), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and architectural shadow ----------------
  logic [255:0] mem_img    [logic [31:0]];
  logic [255:0] shadow_img [logic [31:0]];

  function automatic logic [255:0] pat_line(logic [31:0] a);
    for (int w = 0; w < 8; w++) pat_line[w*32 +: 32] = (a + 32'(w * 4)) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [255:0] mem_get(logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return pat_line(a);
  endfunction

  function automatic logic [255:0] shadow_get(logic [31:0] a);
    if (shadow_img.exists(a)) return shadow_img[a];
    return pat_line(a);
  endfunction

  function automatic logic [255:0] be_bits(logic [31:0] be);
    for (int b = 0; b < 32; b++) be_bits[b*8 +: 8] = {8{be[b]}};
  endfunction

  function automatic logic [31:0] expect_word(logic [31:0] a);
    logic [255:0] ln;
    ln = shadow_get({a[31:5], 5'b0});
    return ln[a[4:2]*32 +: 32];
  endfunction

  task automatic shadow_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    logic [255:0] ln;
    int nb, start;
    ln    = shadow_get({a[31:5], 5'b0});
    nb    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    start = int'(a[4:0]) & ~(nb - 1);
    for (int i = 0; i < nb; i++) ln[(start + i)*8 +: 8] = wd[((start + i) % 4)*8 +: 8];
    shadow_img[{a[31:5], 5'b0}] = ln;
  endtask

  int           op_seq = 0, n_fill = 0, n_wb = 0, fill_seq = 0, wb_seq = 0, hold_err = 0;
  logic [31:0]  wb_addr = '0, wb_be = '0, fill_addr = '0, cap_addr, cap_be;
  logic [255:0] wb_data = '0, cap_data;
  logic         cap_wr;

  // Memory responder: holds ready low one extra cycle to observe request stability.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        cap_addr = mem_req_addr;
        cap_wr   = mem_req_write;
        @(negedge clk);
        if (!mem_req_valid || mem_req_addr != cap_addr || mem_req_write != cap_wr) hold_err++;
        cap_be   = mem_req_be;
        cap_data = mem_req_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        op_seq++;
        if (cap_wr) begin
          n_wb++;
          wb_seq  = op_seq;
          wb_addr = cap_addr;
          wb_be   = cap_be;
          wb_data = cap_data;
          mem_img[cap_addr] = (mem_get(cap_addr) & ~be_bits(cap_be)) | (cap_data & be_bits(cap_be));
        end else begin
          n_fill++;
          fill_seq  = op_seq;
          fill_addr = cap_addr;
          repeat (2) @(negedge clk);
          mem_rsp_rdata = mem_get(cap_addr);
          mem_rsp_valid = 1'b1;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  // ---------------- CPU access task ----------------
  task automatic cpu_op(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat,
                        output bit stall_ok);
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    cpu_req_size  = sz;
    cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 0;
    stall_ok = 1'b1;
    while (!cpu_rsp_valid) begin
      if (mem_req_valid && cpu_req_ready) stall_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    rd = cpu_rsp_rdata;
    if (wr) shadow_write(a, sz, wd);
  endtask

  localparam logic [31:0] A_LN = 32'h0000_0200;
  localparam logic [31:0] X_LN = 32'h0000_0400;
  localparam logic [31:0] STEP = 32'h0000_2000;

  logic [31:0] rd;
  int          lat;
  bit          stall_ok;

  task automatic t_reset();
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R12", "ready after reset", 256'(cpu_req_ready), 256'd1);
    check(mem_req_valid == 1'b0, "R12", "no mem request after reset", 256'(mem_req_valid), 256'd0);
    check(cpu_rsp_valid == 1'b0, "R12", "no response after reset", 256'(cpu_rsp_valid), 256'd0);
  endtask

  task automatic t_read_miss_hit();
    cpu_op(1'b0, A_LN + 32'h4, 2'd2, '0, rd, lat, stall_ok);
    check(rd == expect_word(A_LN + 32'h4), "R6", "read miss data", 256'(rd), 256'(expect_word(A_LN + 32'h4)));
    check(n_fill == 1 && fill_addr == A_LN, "R6", "one line fill at line address", 256'(fill_addr), 256'(A_LN));
    check(stall_ok && lat > 1, "R11", "stalled during miss", 256'(lat), 256'd2);
    cpu_op(1'b0, A_LN + 32'h8, 2'd2, '0, rd, lat, stall_ok);
    check(rd == expect_word(A_LN + 32'h8), "R3", "read hit word", 256'(rd), 256'(expect_word(A_LN + 32'h8)));
    check(lat == 1 && n_fill == 1, "R2", "hit latency one cycle, no fill", 256'(lat), 256'd1);
  endtask

  task automatic t_write_sizes();
    int ops;
    ops = op_seq;
    cpu_op(1'b1, A_LN + 32'h11, 2'd0, 32'h0000_AB00, rd, lat, stall_ok);
    cpu_op(1'b1, A_LN + 32'h16, 2'd1, 32'hCDEF_0000, rd, lat, stall_ok);
    cpu_op(1'b1, A_LN + 32'h1C, 2'd2, 32'h1234_5678, rd, lat, stall_ok);
    check(op_seq == ops, "R5", "write hits cause no memory traffic", 256'(op_seq), 256'(ops));
    cpu_op(1'b0, A_LN + 32'h10, 2'd2, '0, rd, lat, stall_ok);
    check(rd == expect_word(A_LN + 32'h10), "R4", "byte write merged", 256'(rd), 256'(expect_word(A_LN + 32'h10)));
    cpu_op(1'b0, A_LN + 32'h14, 2'd2, '0, rd, lat, stall_ok);
    check(rd == expect_word(A_LN + 32'h14), "R4", "halfword write merged", 256'(rd), 256'(expect_word(A_LN + 32'h14)));
    cpu_op(1'b0, A_LN + 32'h1C, 2'd2, '0, rd, lat, stall_ok);
    check(rd == 32'h1234_5678, "R4", "word write", 256'(rd), 256'h1234_5678);
  endtask

  task automatic t_write_miss();
    int f;
    f = n_fill;
    cpu_op(1'b1, X_LN + 32'h8, 2'd2, 32'hDEAD_BEEF, rd, lat, stall_ok);
    check(n_fill == f + 1 && fill_addr == X_LN, "R7", "write miss fills line", 256'(fill_addr), 256'(X_LN));
    cpu_op(1'b0, X_LN + 32'h8, 2'd2, '0, rd, lat, stall_ok);
    check(rd == 32'hDEAD_BEEF && lat == 1, "R7", "write miss data merged", 256'(rd), 256'hDEAD_BEEF);
    cpu_op(1'b0, X_LN + 32'hC, 2'd2, '0, rd, lat, stall_ok);
    check(rd == expect_word(X_LN + 32'hC), "R7", "neighbour word from fill", 256'(rd), 256'(expect_word(X_LN + 32'hC)));
  endtask

  task automatic t_fill_ways();
    for (int k = 1; k < 4; k++) cpu_op(1'b0, A_LN + STEP * 32'(k), 2'd2, '0, rd, lat, stall_ok);
    check(n_wb == 0, "R10", "invalid ways taken before dirty line evicted", 256'(n_wb), 256'd0);
    cpu_op(1'b1, A_LN + STEP * 2, 2'd2, 32'h0BAD_F00D, rd, lat, stall_ok);
    check(lat == 1, "R5", "store to resident line is a hit", 256'(lat), 256'd1);
  endtask

  task automatic t_dirty_evict();
    logic [255:0] m;
    cpu_op(1'b0, A_LN + STEP * 4, 2'd2, '0, rd, lat, stall_ok);
    check(n_wb == 1 && wb_addr == A_LN, "R8", "dirty victim written back", 256'(wb_addr), 256'(A_LN));
    check(wb_be == 32'hF0C2_0000, "R8", "writeback byte mask", 256'(wb_be), 256'hF0C2_0000);
    m = be_bits(32'hF0C2_0000);
    check((wb_data & m) == (shadow_get(A_LN) & m), "R8", "writeback dirty bytes",
          wb_data & m, shadow_get(A_LN) & m);
    check(wb_seq < fill_seq && fill_addr == A_LN + STEP * 4, "R8", "writeback precedes fill",
          256'(wb_seq), 256'(fill_seq));
    check(rd == expect_word(A_LN + STEP * 4), "R6", "data after eviction", 256'(rd),
          256'(expect_word(A_LN + STEP * 4)));
  endtask

  task automatic t_clean_evict();
    int w;
    w = n_wb;
    cpu_op(1'b0, A_LN + 32'h10, 2'd2, '0, rd, lat, stall_ok);
    check(n_wb == w, "R9", "clean victim has no writeback", 256'(n_wb), 256'(w));
    check(rd == expect_word(A_LN + 32'h10), "R8", "written-back byte returns from memory", 256'(rd),
          256'(expect_word(A_LN + 32'h10)));
  endtask

  task automatic t_rr_next();
    cpu_op(1'b0, A_LN + STEP, 2'd2, '0, rd, lat, stall_ok);
    check(wb_addr == A_LN + STEP * 2, "R10", "round-robin victim is third way", 256'(wb_addr),
          256'(A_LN + STEP * 2));
    check(wb_be == 32'h0000_000F, "R10", "mask of third way", 256'(wb_be), 256'h0000_000F);
  endtask

  task automatic t_set_isolation();
    cpu_op(1'b0, X_LN + 32'h8, 2'd2, '0, rd, lat, stall_ok);
    check(lat == 1 && rd == 32'hDEAD_BEEF, "R1", "other set untouched by conflicts", 256'(rd), 256'hDEAD_BEEF);
    check(hold_err == 0, "R13", "memory request held until accepted", 256'(hold_err), 256'd0);
  endtask

  initial begin
    rst_n         = 1'b0;
    cpu_req_valid = 1'b0;
    cpu_req_write = 1'b0;
    cpu_req_addr  = '0;
    cpu_req_size  = '0;
    cpu_req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_miss_hit();
    t_write_sizes();
    t_write_miss();
    t_fill_ways();
    t_dirty_evict();
    t_clean_evict();
    t_rr_next();
    t_set_isolation();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=response");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule